// File: doc/BRIEF.md
# Serial Command Slave with Status Echo and Byte-Level Flow Control

This block is the serial front end of a command-driven peripheral. A host selects it, clocks in one command byte and then any number of data bytes. The protocol runs with the clock idling high, data sampled on the rising edge and the most significant bit first. While the command byte comes in, the block shifts out a live status byte, so the host learns the device state without a separate read. The block does not decode the command. It hands the command byte to the core, and the core tells it in the same cycle whether the data phase flows from host to core or from core to host.

Data bytes in either direction pass through one buffer of parameterised depth, 32 bytes by default. After any byte the block may drop its ready output. It does this on a write when the buffer has just filled, and on a read when no byte is waiting to be sent. The host must then hold the serial clock high until ready returns. If the host clocks anyway, the edge is ignored and a sticky error clears the ready bit of the status byte. The host sees that bit at the start of its next transaction and can resend.

All pins are brought into the system clock domain through synchronisers. The system clock must run at least four times as fast as the serial clock.

Top module: `spi_stat_slave`

## Requirements
- R1: Bits are sampled on rising serial-clock edges, most significant bit first. At the end of the first byte of a transaction, `cmd_valid_o` pulses for exactly one cycle with that byte on `cmd_byte_o`.
- R2: During the first byte, MISO carries the status byte, MSB first. Its bits are: bit 7 power-down (`core_pd_i`), bit 6 ready (1 unless a stall violation is pending), bit 5 interrupt (`core_int_i`), bit 4 buffer full, bit 0 command busy (`core_cmd_bsy_i`). Bits 3 to 1 are zero.
- R3: `miso_oe_o` is low whenever `ss_n_i` is high and high while it is low.
- R4: In write mode (`rd_mode_i` low when the command byte completes), each following byte enters the buffer and reaches the core on `rx_data_o` in arrival order. MISO sends 0x00 during these bytes.
- R5: In write mode, when a byte fills the buffer, `rdy_o` goes low. It stays low until the core removes a byte, then returns high.
- R6: In read mode (`rd_mode_i` high when the command byte completes), bytes the core pushes are shifted out MSB first, one per byte slot. At a byte boundary with an empty buffer, `rdy_o` goes low until the core pushes a byte.
- R7: A serial clock edge while `rdy_o` is low is ignored and drives `stat_rdy_o` low. The next transaction reports ready bit 0 in its status byte, and `stat_rdy_o` returns high once that status byte is loaded.
- R8: Raising `ss_n_i` discards a partial byte, empties the buffer and leaves `rdy_o` high. The next transaction starts a fresh command byte.
- R9: After reset, `rdy_o` and `stat_rdy_o` are high and `miso_oe_o`, `cmd_valid_o` and `rx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n_i | input | 1 | Slave select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| core_pd_i | input | 1 | Power-down flag for the status byte |
| core_int_i | input | 1 | Interrupt flag for the status byte |
| core_cmd_bsy_i | input | 1 | Command-busy flag for the status byte |
| rd_mode_i | input | 1 | Direction of the data phase, sampled when the command byte completes |
| cmd_valid_o | output | 1 | One-cycle pulse: command byte received |
| cmd_byte_o | output | 8 | Received command byte |
| rx_valid_o | output | 1 | Write data available to the core |
| rx_ready_i | input | 1 | Core accepts write data |
| rx_data_o | output | 8 | Write data byte |
| tx_valid_i | input | 1 | Core offers read data |
| tx_ready_o | output | 1 | Block accepts read data |
| tx_data_i | input | 8 | Read data byte |
| rdy_o | output | 1 | Ready (high) / busy (low) to the host |
| stat_rdy_o | output | 1 | Current value of the status ready bit |

## Verification
A pin change is seen by the logic three clock edges after it happens: two synchroniser stages, then the edge register. Registered results follow one cycle later. MISO changes about three cycles after a falling serial clock edge. The command pulse and any new ready level appear four to five cycles after the last rising edge of a byte. The bench holds each serial clock half-period for six system cycles and samples MISO just before raising the clock, so every shifted bit has settled. Ready, buffer and status-flag checks come at least eight cycles after the edge that caused them. The bench polls ready only through a bounded wait.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);

    // status bit positions, decoded by the host
    localparam int ST_PD   = 7;
    localparam int ST_RDY  = 6;
    localparam int ST_INT  = 5;
    localparam int ST_FULL = 4;
    localparam int ST_BSY  = 0;

    typedef logic [BYTE_W-1:0] byte_t;

    function automatic byte_t pack_status(input logic pd, input logic rdy,
                                          input logic irq, input logic full,
                                          input logic bsy);
        byte_t s;
        s          = '0;
        s[ST_PD]   = pd;
        s[ST_RDY]  = rdy;
        s[ST_INT]  = irq;
        s[ST_FULL] = full;
        s[ST_BSY]  = bsy;
        return s;
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       push_i,
    input  logic [W-1:0]               push_data_i,
    input  logic                       pop_i,
    output logic [W-1:0]               pop_data_o,
    output logic                       full_o,
    output logic                       empty_o,
    output logic [$clog2(DEPTH):0]     count_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full_o     = (q.cnt == CW'(DEPTH));
    assign empty_o    = (q.cnt == '0);
    assign count_o    = q.cnt;
    assign pop_data_o = mem[q.rd];
    assign do_push    = push_i && !full_o && !flush_i;
    assign do_pop     = pop_i && !empty_o && !flush_i;

    always_comb begin
        d = q;
        if (flush_i) begin
            d = '0;
        end else begin
            if (do_push) d.wr = (q.wr == AW'(DEPTH-1)) ? '0 : q.wr + 1'b1;
            if (do_pop)  d.rd = (q.rd == AW'(DEPTH-1)) ? '0 : q.rd + 1'b1;
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= push_data_i;
    end
endmodule

// File: rtl/spi_stat_slave.sv
module spi_stat_slave
    import spi_stat_pkg::*;
#(
    parameter int BUF_DEPTH   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ss_n_i,
    input  logic        sclk_i,
    input  logic        mosi_i,
    output logic        miso_o,
    output logic        miso_oe_o,
    input  logic        core_pd_i,
    input  logic        core_int_i,
    input  logic        core_cmd_bsy_i,
    input  logic        rd_mode_i,
    output logic        cmd_valid_o,
    output logic [7:0]  cmd_byte_o,
    output logic        rx_valid_o,
    input  logic        rx_ready_i,
    output logic [7:0]  rx_data_o,
    input  logic        tx_valid_i,
    output logic        tx_ready_o,
    input  logic [7:0]  tx_data_i,
    output logic        rdy_o,
    output logic        stat_rdy_o
);
    localparam int CNT_W = $clog2(BUF_DEPTH) + 1;

    typedef struct packed {
        logic [BIT_CW-1:0] bit_cnt;
        byte_t             rx_sh;
        byte_t             tx_sh;
        logic              first;
        logic              done;
        logic              done_cmd;
        byte_t             done_byte;
        logic              busy;
        logic              viol;
        logic              rd_mode;
        logic              cmd_valid;
        byte_t             cmd_byte;
        logic              sclk_prev;
        logic              ss_prev;
    } slv_st_t;

    localparam slv_st_t ST_RST = '{
        bit_cnt: '0, rx_sh: '0, tx_sh: '0, first: 1'b1, done: 1'b0,
        done_cmd: 1'b0, done_byte: '0, busy: 1'b0, viol: 1'b0,
        rd_mode: 1'b0, cmd_valid: 1'b0, cmd_byte: '0,
        sclk_prev: 1'b1, ss_prev: 1'b1
    };

    slv_st_t q, d;

    // synchronised pins: {ss_n, sclk, mosi}
    logic [2:0] pins_s;
    logic       s_ss, s_sclk, s_mosi;

    spi_pin_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({ss_n_i, sclk_i, mosi_i}),
        .sync_o (pins_s)
    );

    assign s_ss   = pins_s[2];
    assign s_sclk = pins_s[1];
    assign s_mosi = pins_s[0];

    // buffer
    logic               fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic               spi_push, spi_pop, core_push, core_pop;
    byte_t              fifo_wdata, fifo_rdata;
    logic [CNT_W-1:0]   fifo_count;

    spi_byte_fifo #(
        .DEPTH (BUF_DEPTH),
        .W     (BYTE_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (s_ss),
        .push_i      (fifo_push),
        .push_data_i (fifo_wdata),
        .pop_i       (fifo_pop),
        .pop_data_o  (fifo_rdata),
        .full_o      (fifo_full),
        .empty_o     (fifo_empty),
        .count_o     (fifo_count)
    );

    logic sclk_rise, sclk_fall, ss_fall, rd_now;

    assign sclk_rise = !s_ss && s_sclk && !q.sclk_prev;
    assign sclk_fall = !s_ss && !s_sclk && q.sclk_prev;
    assign ss_fall   = !s_ss && q.ss_prev;

    assign tx_ready_o = !s_ss && q.rd_mode && !fifo_full;
    assign core_push  = tx_valid_i && tx_ready_o;
    assign rx_valid_o = !q.rd_mode && !fifo_empty;
    assign core_pop   = rx_valid_o && rx_ready_i;
    assign rx_data_o  = fifo_rdata;

    assign fifo_push  = spi_push || core_push;
    assign fifo_wdata = spi_push ? q.done_byte : tx_data_i;
    assign fifo_pop   = spi_pop || core_pop;

    always_comb begin
        d           = q;
        d.sclk_prev = s_sclk;
        d.ss_prev   = s_ss;
        d.done      = 1'b0;
        d.cmd_valid = 1'b0;
        spi_push    = 1'b0;
        spi_pop     = 1'b0;
        rd_now      = q.done_cmd ? rd_mode_i : q.rd_mode;

        if (s_ss) begin
            d.bit_cnt = '0;
            d.rx_sh   = '0;
            d.first   = 1'b1;
            d.busy    = 1'b0;
            d.rd_mode = 1'b0;
        end else if (ss_fall) begin
            d.tx_sh   = pack_status(core_pd_i, !q.viol, core_int_i,
                                    fifo_full, core_cmd_bsy_i);
            d.viol    = 1'b0;
            d.first   = 1'b1;
            d.bit_cnt = '0;
        end else begin
            // serial bit timing
            if (q.busy && (sclk_rise || sclk_fall)) begin
                d.viol = 1'b1;
            end else if (sclk_rise) begin
                d.rx_sh   = {q.rx_sh[BYTE_W-2:0], s_mosi};
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.bit_cnt == BIT_CW'(BYTE_W-1)) begin
                    d.done      = 1'b1;
                    d.done_cmd  = q.first;
                    d.done_byte = {q.rx_sh[BYTE_W-2:0], s_mosi};
                    d.first     = 1'b0;
                end
            end else if (sclk_fall && q.bit_cnt != '0) begin
                d.tx_sh = {q.tx_sh[BYTE_W-2:0], 1'b0};
            end

            // byte boundary and pause handling
            if (q.done) begin
                if (q.done_cmd) begin
                    d.cmd_valid = 1'b1;
                    d.cmd_byte  = q.done_byte;
                    d.rd_mode   = rd_mode_i;
                end
                if (rd_now) begin
                    if (!fifo_empty) begin
                        spi_pop = 1'b1;
                        d.tx_sh = fifo_rdata;
                    end else begin
                        d.busy = 1'b1;
                    end
                end else begin
                    d.tx_sh = '0;
                    if (!q.done_cmd) begin
                        spi_push = 1'b1;
                        if (fifo_count == CNT_W'(BUF_DEPTH-1)) d.busy = 1'b1;
                    end
                end
            end else if (q.busy) begin
                if (q.rd_mode) begin
                    if (!fifo_empty) begin
                        spi_pop = 1'b1;
                        d.tx_sh = fifo_rdata;
                        d.busy  = 1'b0;
                    end
                end else if (!fifo_full) begin
                    d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign miso_o      = q.tx_sh[BYTE_W-1];
    assign miso_oe_o   = !ss_n_i;
    assign cmd_valid_o = q.cmd_valid;
    assign cmd_byte_o  = q.cmd_byte;
    assign rdy_o       = !q.busy;
    assign stat_rdy_o  = !q.viol;
endmodule

// File: rtl/spi_stat_slave_chk.sv
module spi_stat_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_n_i,
    input logic rdy_o,
    input logic stat_rdy_o,
    input logic cmd_valid_o,
    input logic rx_valid_o,
    input logic fifo_full,
    input logic fifo_empty,
    input logic fifo_push,
    input logic fifo_pop
);
    logic [2:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cyc_q <= '0;
        else if (cyc_q != 3'd7) cyc_q <= cyc_q + 1'b1;
    end

    // R1: command strobe is a single-cycle pulse
    a_r1_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R5: the buffer is never written while full
    a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_push);

    // R6: the buffer is never read while empty
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R7: the status ready bit only drops after a cycle of busy
    a_r7_viol_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd2) && $fell(stat_rdy_o) |-> $past(!rdy_o));

    // R8: a released select leaves the block ready with an empty buffer
    a_r8_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd5) && ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2)
        && $past(ss_n_i, 3) && $past(ss_n_i, 4) |-> rdy_o && !rx_valid_o);
endmodule

bind spi_stat_slave spi_stat_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ss_n_i      (ss_n_i),
    .rdy_o       (rdy_o),
    .stat_rdy_o  (stat_rdy_o),
    .cmd_valid_o (cmd_valid_o),
    .rx_valid_o  (rx_valid_o),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop)
);

// File: tb/spi_stat_slave_tb.sv
`timescale 1ns/1ps
module spi_stat_slave_tb;
    localparam int H     = 6;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss_n = 1'b1, sclk = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic pd = 1'b0, irq = 1'b0, bsy = 1'b0, rd_mode = 1'b0;
    logic cmd_valid;
    logic [7:0] cmd_byte;
    logic rx_valid, rx_ready = 1'b0;
    logic [7:0] rx_data;
    logic tx_valid = 1'b0, tx_ready;
    logic [7:0] tx_data = '0;
    logic rdy, stat_rdy;

    int checks = 0, errors = 0;
    int ncmd = 0, nrx = 0;
    logic [7:0] last_cmd = '0;
    logic [7:0] rx_log [64];
    logic [7:0] got;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    spi_stat_slave #(.BUF_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ss_n_i(ss_n), .sclk_i(sclk), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .core_pd_i(pd), .core_int_i(irq),
        .core_cmd_bsy_i(bsy), .rd_mode_i(rd_mode), .cmd_valid_o(cmd_valid),
        .cmd_byte_o(cmd_byte), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
        .rx_data_o(rx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .tx_data_i(tx_data), .rdy_o(rdy), .stat_rdy_o(stat_rdy)
    );

    // core-side monitors
    always @(posedge clk) begin
        if (cmd_valid) begin
            last_cmd <= cmd_byte;
            ncmd     <= ncmd + 1;
        end
        if (rx_valid && rx_ready && nrx < 64) begin
            rx_log[nrx] <= rx_data;
            nrx         <= nrx + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sel;
        @(negedge clk) ss_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic desel;
        @(negedge clk) ss_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk) sclk = 1'b0; mosi = mo[b];
            repeat (H) @(negedge clk);
            mi[b] = miso;
            sclk = 1'b1;
            repeat (H - 1) @(negedge clk);
        end
    endtask

    task automatic wait_rdy;
        repeat (8) @(negedge clk);
        while (!rdy) @(negedge clk);
    endtask

    task automatic core_push(input logic [7:0] v);
        @(negedge clk) tx_valid = 1'b1; tx_data = v;
        @(posedge clk);
        while (!tx_ready) @(posedge clk);
        @(negedge clk) tx_valid = 1'b0;
    endtask

    // {pd, int, cmd_bsy, command, expected status}
    localparam logic [18:0] VEC [4] = '{
        {3'b101, 8'h01, 8'hC1},
        {3'b010, 8'hA5, 8'h60},
        {3'b000, 8'h3C, 8'h40},
        {3'b111, 8'hFF, 8'hE1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 reset state
        chk(rdy === 1'b1, "R9 rdy", rdy, 1);
        chk(stat_rdy === 1'b1, "R9 stat_rdy", stat_rdy, 1);
        chk(miso_oe === 1'b0, "R9/R3 miso_oe", miso_oe, 0);
        chk(cmd_valid === 1'b0 && rx_valid === 1'b0, "R9 strobes", {cmd_valid, rx_valid}, 0);

        // R2/R1 table: status echo and command capture
        foreach (VEC[i]) begin
            {pd, irq, bsy} = VEC[i][18:16];
            n0 = ncmd;
            sel();
            chk(miso_oe === 1'b1, "R3 oe selected", miso_oe, 1);
            xfer(VEC[i][15:8], got);
            repeat (8) @(negedge clk);
            chk(got == VEC[i][7:0], "R2 status byte", got, VEC[i][7:0]);
            chk(last_cmd == VEC[i][15:8] && ncmd == n0 + 1, "R1 command", last_cmd, VEC[i][15:8]);
            desel();
            chk(miso_oe === 1'b0, "R3 oe released", miso_oe, 0);
        end
        {pd, irq, bsy} = 3'b000;

        // R4 write path, drained by the core
        rx_ready = 1'b1;
        rd_mode  = 1'b0;
        sel();
        xfer(8'h02, got);
        wait_rdy();
        xfer(8'hA5, got); wait_rdy();
        chk(got == 8'h00, "R4 miso zero in write", got, 0);
        xfer(8'h3C, got); wait_rdy();
        xfer(8'h0F, got); wait_rdy();
        desel();
        chk(nrx == 3, "R4 byte count", nrx, 3);
        chk(rx_log[0] == 8'hA5 && rx_log[1] == 8'h3C && rx_log[2] == 8'h0F,
            "R4 order", {rx_log[0], rx_log[1], rx_log[2]}, 24'hA53C0F);

        // R5 fill the buffer, R7 clock during busy, R8 flush
        rx_ready = 1'b0;
        sel();
        xfer(8'h02, got);
        wait_rdy();
        for (int k = 0; k < DEPTH; k++) begin
            xfer(8'h40 + 8'(k), got);
            if (k < DEPTH - 1) begin
                repeat (8) @(negedge clk);
                if (k == DEPTH - 2) chk(rdy === 1'b1, "R5 ready before full", rdy, 1);
            end
        end
        repeat (8) @(negedge clk);
        chk(rdy === 1'b0, "R5 busy when full", rdy, 0);
        chk(stat_rdy === 1'b1, "R7 no violation yet", stat_rdy, 1);
        @(negedge clk) sclk = 1'b0;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        chk(stat_rdy === 1'b0, "R7 violation flagged", stat_rdy, 0);
        @(negedge clk) rx_ready = 1'b1;
        @(negedge clk) rx_ready = 1'b0;
        repeat (6) @(negedge clk);
        chk(rdy === 1'b1, "R5 ready after pop", rdy, 1);
        chk(rx_log[3] == 8'h40, "R4 first buffered byte", rx_log[3], 8'h40);
        desel();
        chk(rx_valid === 1'b0, "R8 buffer flushed", rx_valid, 0);
        chk(rdy === 1'b1, "R8 ready when idle", rdy, 1);

        // R7 report in next status byte
        sel();
        chk(stat_rdy === 1'b1, "R7 cleared after load", stat_rdy, 1);
        xfer(8'h05, got);
        chk(got == 8'h00, "R7 status ready bit 0", got, 8'h00);
        desel();

        // R8 partial byte discarded
        sel();
        for (int b = 0; b < 3; b++) begin
            @(negedge clk) sclk = 1'b0; mosi = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        desel();
        n0 = ncmd;
        sel();
        xfer(8'h77, got);
        repeat (8) @(negedge clk);
        chk(last_cmd == 8'h77 && ncmd == n0 + 1, "R8 fresh command", last_cmd, 8'h77);
        desel();

        // R6 read path with empty-buffer stall
        rd_mode = 1'b1;
        sel();
        xfer(8'h0B, got);
        repeat (8) @(negedge clk);
        chk(rdy === 1'b0, "R6 busy when empty", rdy, 0);
        core_push(8'h96);
        core_push(8'h5A);
        wait_rdy();
        chk(rdy === 1'b1, "R6 ready after push", rdy, 1);
        xfer(8'h00, got);
        wait_rdy();
        chk(got == 8'h96, "R6 first read byte", got, 8'h96);
        xfer(8'h00, got);
        chk(got == 8'h5A, "R6 second read byte", got, 8'h5A);
        repeat (8) @(negedge clk);
        chk(rdy === 1'b0, "R6 busy after drain", rdy, 0);
        desel();
        rd_mode = 1'b0;
        chk(rdy === 1'b1, "R8 ready after read", rdy, 1);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule